// File: doc/BRIEF.md
# Dual-Product Accumulator With Cascade

This block multiplies two pairs of signed 12-bit operands and adds the two products. Each product can be negated on its own. A signed 16-bit cascade word can be added into the upper part of a 24-bit accumulator. Each new item either starts a fresh sum or adds onto the running one. When a fresh sum starts, an optional half-LSB rounding constant for a 16-bit result is added. The result leaves through a 16-bit output register. That register normally shows the upper word of the accumulator. It can also hold a snapshot and alternate between the overlapping upper and lower words.

Operands and their per-item controls enter as a stream qualified by `in_valid`. The block has no back-pressure. The pipeline never stalls and accepts one item on every clock, and a cycle with `in_valid` low is a bubble. The sink must take every word while `out_valid` is high, because the block provides no ready input. The cascade port and the output-side controls (`show_high`, `out_en`) are plain pins that are sampled every clock.

Top module: `dual_product_accum`

## Requirements
- R1: For each valid item, the value added to the accumulator is (±A·B) + (±C·D), with all operands as two's-complement 12-bit numbers. A product is negated when its control (`neg_ab` for A·B, `neg_cd` for C·D) is 1 in the same clock as the operands.
- R2: With `show_high` held at 1, the result of an item presented in the clock before rising edge k appears on `out_word` after edge k+5. That is six registered edges, counting the capture edge as the first.
- R3: An item with `accum` = 0 replaces the accumulator contents. An item with `accum` = 1 adds to the previous contents.
- R4: When `round_en` = 1 and `accum` = 0, the value 2^7 is added to the new sum. When `accum` = 1, nothing is added, whatever `round_en` is.
- R5: The cascade word is two's complement and is added with its LSB at accumulator bit 8. It is added only when `casc_ignore` = 0 in the clock the word is presented. When `casc_ignore` = 1, it contributes nothing.
- R6: If `casc_fast` = 0 for an item, the cascade word presented in the same clock as that item is used. If `casc_fast` = 1, the cascade word presented three clocks after the item is used.
- R7: A clock with `in_valid` = 0 leaves the accumulator unchanged. The output slot that belongs to that clock has `out_valid` = 0.
- R8: On an edge where `show_high` = 1, the output register loads accumulator bits 23..8 and keeps a snapshot of bits 23..8 and 15..0. On each edge where `show_high` = 0, the output switches to the other snapshot word, starting with bits 15..0, and loads no new data.
- R9: `out_valid` is the registered valid flag ANDed with `out_en`. `out_en` has no effect on `out_word`.
- R10: The accumulator wraps modulo 2^24 and does not saturate.
- R11: After a synchronous reset, `out_word` is 0 and `out_valid` is 0, and the accumulator and all pipeline stages are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the operands and per-item controls |
| opd_a | input | 12 | Operand A, signed |
| opd_b | input | 12 | Operand B, signed |
| opd_c | input | 12 | Operand C, signed |
| opd_d | input | 12 | Operand D, signed |
| neg_ab | input | 1 | Negate product A·B |
| neg_cd | input | 1 | Negate product C·D |
| round_en | input | 1 | Add half-LSB rounding on a fresh sum |
| accum | input | 1 | 1 adds to the running sum, 0 starts a new sum |
| casc_word | input | 16 | Signed cascade word, weight 2^8 at its LSB |
| casc_ignore | input | 1 | 1 discards the cascade word of this clock |
| casc_fast | input | 1 | 1 selects the short cascade path for this item |
| show_high | input | 1 | 1 loads the upper word, 0 alternates the held words |
| out_en | input | 1 | Enables `out_valid` |
| out_word | output | 16 | Output word register |
| out_valid | output | 1 | Output word is a valid result |

## Verification
A corrupted accumulator does not stay local. Every later result in the same run carries the error, and the damage stops only at the next item with `accum` = 0, so one bad state can show on several consecutive outputs six clocks behind its cause. A misaligned cascade or control stage moves the error by whole clocks. That shows as the right values paired with the wrong items, and only once the cascade or negation pattern varies from clock to clock. A wrong toggle phase shows on the very first edge with `show_high` low, where the upper word appears in place of the lower one.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  // Per-item controls that travel with the operands down the pipe.
  typedef struct packed {
    logic vld;
    logic neg_ab;
    logic neg_cd;
    logic round_en;
    logic accum;
    logic casc_fast;
  } dpm_ctrl_t;
endpackage

// File: rtl/dpm_product_stage.sv
module dpm_product_stage
  import dpm_pkg::*;
#(
  parameter int DW = 12,
  parameter int PW = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [4*DW-1:0]      opd_bus,
  input  dpm_ctrl_t            ctrl_in,
  output logic signed [PW-1:0] sum_out,
  output dpm_ctrl_t            ctrl_out
);
  localparam int NLANE = 2;

  logic [DW-1:0]        x_q    [NLANE];
  logic [DW-1:0]        y_q    [NLANE];
  logic signed [PW-1:0] prod_q [NLANE];
  logic signed [PW-1:0] term   [NLANE];
  logic                 neg_sel[NLANE];
  dpm_ctrl_t            c1_q, c2_q;

  assign neg_sel[0] = c2_q.neg_ab;
  assign neg_sel[1] = c2_q.neg_cd;

  // One lane per multiplier: capture, multiply, apply sign.
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        x_q[g]    <= '0;
        y_q[g]    <= '0;
        prod_q[g] <= '0;
      end else begin
        x_q[g]    <= opd_bus[(2*g)*DW +: DW];
        y_q[g]    <= opd_bus[(2*g+1)*DW +: DW];
        prod_q[g] <= PW'($signed(x_q[g])) * PW'($signed(y_q[g]));
      end
    end
    assign term[g] = neg_sel[g] ? -prod_q[g] : prod_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c1_q     <= '0;
      c2_q     <= '0;
      ctrl_out <= '0;
      sum_out  <= '0;
    end else begin
      c1_q     <= ctrl_in;
      c2_q     <= c1_q;
      ctrl_out <= c2_q;
      sum_out  <= term[0] + term[1];
    end
  end
endmodule

// File: rtl/dpm_casc_line.sv
module dpm_casc_line #(
  parameter int CW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] word_in,
  input  logic          ign_in,
  output logic [CW-1:0] first_word,
  output logic          first_ign,
  output logic [CW-1:0] last_word,
  output logic          last_ign
);
  logic [CW-1:0] w_q [DEPTH];
  logic          i_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          w_q[k] <= '0;
          i_q[k] <= 1'b1;
        end else begin
          w_q[k] <= word_in;
          i_q[k] <= ign_in;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          w_q[k] <= '0;
          i_q[k] <= 1'b1;
        end else begin
          w_q[k] <= w_q[k-1];
          i_q[k] <= i_q[k-1];
        end
      end
    end
  end

  assign first_word = w_q[0];
  assign first_ign  = i_q[0];
  assign last_word  = w_q[DEPTH-1];
  assign last_ign   = i_q[DEPTH-1];
endmodule

// File: rtl/dpm_accum.sv
module dpm_accum
  import dpm_pkg::*;
#(
  parameter int ACCW = 24,
  parameter int CW   = 16,
  parameter int OW   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic signed [ACCW-1:0] sum_in,
  input  dpm_ctrl_t              ctrl_in,
  input  logic [CW-1:0]          slow_word,
  input  logic                   slow_ign,
  input  logic [CW-1:0]          fast_word,
  input  logic                   fast_ign,
  output logic [ACCW-1:0]        acc_q,
  output logic                   acc_vld
);
  localparam int RB = ACCW - OW - 1;
  localparam int SH = ACCW - CW;
  localparam logic [ACCW-1:0] HALF = ACCW'(1) << RB;

  logic [ACCW-1:0] s4_q;
  dpm_ctrl_t       c4_q;
  logic [CW-1:0]   csel_word;
  logic            csel_ign;
  logic [ACCW-1:0] casc_term;
  logic [ACCW-1:0] base;

  // Rounding stage: only a fresh sum receives the half-LSB constant.
  always_ff @(posedge clk) begin
    if (rst) begin
      s4_q <= '0;
      c4_q <= '0;
    end else begin
      s4_q <= sum_in + ((ctrl_in.round_en && !ctrl_in.accum) ? HALF : '0);
      c4_q <= ctrl_in;
    end
  end

  assign csel_word = c4_q.casc_fast ? fast_word : slow_word;
  assign csel_ign  = c4_q.casc_fast ? fast_ign  : slow_ign;
  assign casc_term = csel_ign ? '0 : {csel_word, {SH{1'b0}}};
  assign base      = c4_q.accum ? acc_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      acc_vld <= 1'b0;
    end else begin
      acc_vld <= c4_q.vld;
      if (c4_q.vld) acc_q <= base + s4_q + casc_term;
    end
  end
endmodule

// File: rtl/dpm_out_word.sv
module dpm_out_word #(
  parameter int ACCW = 24,
  parameter int OW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ACCW-1:0] acc_in,
  input  logic            acc_vld,
  input  logic            show_high,
  output logic [OW-1:0]   word_q,
  output logic            word_vld
);
  logic [OW-1:0] hi_q, lo_q;
  logic          next_lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= '0;
      lo_q      <= '0;
      word_q    <= '0;
      word_vld  <= 1'b0;
      next_lo_q <= 1'b1;
    end else if (show_high) begin
      hi_q      <= acc_in[ACCW-1 -: OW];
      lo_q      <= acc_in[OW-1:0];
      word_q    <= acc_in[ACCW-1 -: OW];
      word_vld  <= acc_vld;
      next_lo_q <= 1'b1;
    end else begin
      word_q    <= next_lo_q ? lo_q : hi_q;
      next_lo_q <= !next_lo_q;
    end
  end
endmodule

// File: rtl/dual_product_accum.sv
module dual_product_accum
  import dpm_pkg::*;
#(
  parameter int DW = 12,
  parameter int CW = 16,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] opd_a,
  input  logic [DW-1:0] opd_b,
  input  logic [DW-1:0] opd_c,
  input  logic [DW-1:0] opd_d,
  input  logic          neg_ab,
  input  logic          neg_cd,
  input  logic          round_en,
  input  logic          accum,
  input  logic [CW-1:0] casc_word,
  input  logic          casc_ignore,
  input  logic          casc_fast,
  input  logic          show_high,
  input  logic          out_en,
  output logic [OW-1:0] out_word,
  output logic          out_valid
);
  localparam int ACCW       = 2 * DW;
  localparam int CASC_DEPTH = 4;

  dpm_ctrl_t              ctrl_in, ctrl3;
  logic signed [ACCW-1:0] sum3;
  logic [CW-1:0]          c_first_w, c_last_w;
  logic                   c_first_i, c_last_i;
  logic [ACCW-1:0]        acc;
  logic                   acc_vld;
  logic                   word_vld;

  always_comb begin
    ctrl_in.vld       = in_valid;
    ctrl_in.neg_ab    = neg_ab;
    ctrl_in.neg_cd    = neg_cd;
    ctrl_in.round_en  = round_en;
    ctrl_in.accum     = accum;
    ctrl_in.casc_fast = casc_fast;
  end

  dpm_product_stage #(.DW(DW), .PW(ACCW)) u_prod (
    .clk(clk), .rst(rst),
    .opd_bus({opd_d, opd_c, opd_b, opd_a}),
    .ctrl_in(ctrl_in),
    .sum_out(sum3),
    .ctrl_out(ctrl3)
  );

  dpm_casc_line #(.CW(CW), .DEPTH(CASC_DEPTH)) u_casc (
    .clk(clk), .rst(rst),
    .word_in(casc_word), .ign_in(casc_ignore),
    .first_word(c_first_w), .first_ign(c_first_i),
    .last_word(c_last_w), .last_ign(c_last_i)
  );

  dpm_accum #(.ACCW(ACCW), .CW(CW), .OW(OW)) u_acc (
    .clk(clk), .rst(rst),
    .sum_in(sum3), .ctrl_in(ctrl3),
    .slow_word(c_last_w), .slow_ign(c_last_i),
    .fast_word(c_first_w), .fast_ign(c_first_i),
    .acc_q(acc), .acc_vld(acc_vld)
  );

  dpm_out_word #(.ACCW(ACCW), .OW(OW)) u_out (
    .clk(clk), .rst(rst),
    .acc_in(acc), .acc_vld(acc_vld),
    .show_high(show_high),
    .word_q(out_word), .word_vld(word_vld)
  );

  assign out_valid = word_vld & out_en;
endmodule

// File: rtl/dual_product_accum_chk.sv
module dual_product_accum_chk #(
  parameter int ACCW = 24,
  parameter int OW   = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          show_high,
  input logic          out_en,
  input logic [OW-1:0] out_word,
  input logic          out_valid
);
  localparam int OV = 2 * OW - ACCW;

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // R7: a loaded output slot is valid exactly when its item was valid.
  p_slot_valid_r7: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd7 && out_en && $past(show_high))
      |-> (out_valid == $past(in_valid, 6)));

  // R8: two toggling edges in a row bring back the same word.
  p_toggle_period_r8: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd2 && !show_high && $past(!show_high))
      |=> (out_word == $past(out_word, 2)));

  // R8: consecutive toggled words share the overlapping bits.
  p_overlap_words_r8: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 3'd0 && !show_high)
      |=> ((out_word[OV-1:0] == $past(out_word[OW-1 -: OV])) ||
           (out_word[OW-1 -: OV] == $past(out_word[OV-1:0]))));

  // R9: no valid word is offered while the output is disabled.
  p_valid_gated_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_en);
endmodule

bind dual_product_accum dual_product_accum_chk #(.ACCW(2 * DW), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .show_high(show_high),
  .out_en(out_en), .out_word(out_word), .out_valid(out_valid)
);

// File: tb/dual_product_accum_tb.sv
module dual_product_accum_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NMAX = 72;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [11:0] opd_a = '0, opd_b = '0, opd_c = '0, opd_d = '0;
  logic neg_ab = 1'b0, neg_cd = 1'b0, round_en = 1'b0, accum = 1'b0;
  logic [15:0] casc_word = '0;
  logic casc_ignore = 1'b1, casc_fast = 1'b0, show_high = 1'b1, out_en = 1'b1;
  logic [15:0] out_word;
  logic out_valid;

  int checks = 0;
  int failures = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic [11:0] s_a [NMAX], s_b [NMAX], s_c [NMAX], s_d [NMAX];
  logic [15:0] s_cas [NMAX];
  logic s_n1 [NMAX], s_n2 [NMAX], s_rnd [NMAX], s_acc [NMAX], s_ign [NMAX];
  logic s_fast [NMAX], s_vld [NMAX], s_show [NMAX], s_en [NMAX];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_product_accum u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .opd_a(opd_a), .opd_b(opd_b), .opd_c(opd_c), .opd_d(opd_d),
    .neg_ab(neg_ab), .neg_cd(neg_cd), .round_en(round_en), .accum(accum),
    .casc_word(casc_word), .casc_ignore(casc_ignore), .casc_fast(casc_fast),
    .show_high(show_high), .out_en(out_en),
    .out_word(out_word), .out_valid(out_valid)
  );

  function automatic logic [15:0] rnd16();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:16];
  endfunction

  task automatic clear_stim();
    for (int i = 0; i < NMAX; i++) begin
      s_a[i] = '0; s_b[i] = '0; s_c[i] = '0; s_d[i] = '0; s_cas[i] = '0;
      s_n1[i] = 0; s_n2[i] = 0; s_rnd[i] = 0; s_acc[i] = 0; s_ign[i] = 1;
      s_fast[i] = 0; s_vld[i] = 0; s_show[i] = 1; s_en[i] = 1;
    end
  endtask

  task automatic fill_random(int n);
    for (int i = 0; i < n; i++) begin
      s_a[i] = rnd16()[11:0]; s_b[i] = rnd16()[11:0];
      s_c[i] = rnd16()[11:0]; s_d[i] = rnd16()[11:0];
      s_vld[i] = 1;
    end
  endtask

  task automatic drive(int i);
    opd_a = s_a[i]; opd_b = s_b[i]; opd_c = s_c[i]; opd_d = s_d[i];
    neg_ab = s_n1[i]; neg_cd = s_n2[i]; round_en = s_rnd[i]; accum = s_acc[i];
    casc_word = s_cas[i]; casc_ignore = s_ign[i]; casc_fast = s_fast[i];
    in_valid = s_vld[i]; show_high = s_show[i]; out_en = s_en[i];
  endtask

  task automatic idle();
    in_valid = 0; opd_a = '0; opd_b = '0; opd_c = '0; opd_d = '0;
    neg_ab = 0; neg_cd = 0; round_en = 0; accum = 0; casc_word = '0;
    casc_ignore = 1; casc_fast = 0; show_high = 1; out_en = 1;
  endtask

  task automatic check(string tag, logic [15:0] gw, logic [15:0] ew, logic gv, logic ev);
    checks++;
    if (gw !== ew || gv !== ev) begin
      failures++;
      $display("FAIL %s: out_word=%h out_valid=%b, expected out_word=%h out_valid=%b",
               tag, gw, gv, ew, ev);
    end
  endtask

  task automatic do_reset();
    rst = 1; idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  // Applies reset, plays stim[0..n-1], drains, and compares every cycle
  // against an item-level model of the requirements.
  task automatic run_seq(string tag, int n);
    logic [23:0] e_acc [NMAX];
    logic        e_v   [NMAX];
    logic [23:0] run;
    logic [15:0] m_hi, m_lo, m_out;
    logic        m_v, m_next_lo;
    run = '0;
    for (int t = 0; t < NMAX; t++) begin
      int pa, pc, term, ci;
      pa = int'($signed(s_a[t])) * int'($signed(s_b[t]));
      pc = int'($signed(s_c[t])) * int'($signed(s_d[t]));
      term = (s_n1[t] ? -pa : pa) + (s_n2[t] ? -pc : pc);
      if (s_rnd[t] && !s_acc[t]) term += 128;
      ci = s_fast[t] ? t + 3 : t;
      if (ci < NMAX && !s_ign[ci]) term += int'($signed(s_cas[ci])) * 256;
      if (s_vld[t]) run = (s_acc[t] ? run : 24'h0) + 24'(term);
      e_acc[t] = run;
      e_v[t] = s_vld[t];
    end
    do_reset();
    m_hi = '0; m_lo = '0; m_out = '0; m_v = 0; m_next_lo = 1;
    for (int i = 0; i < n + 8; i++) begin
      logic [23:0] a_m;
      logic        v_m;
      drive(i);
      @(posedge clk);
      @(negedge clk);
      a_m = (i - 5 >= 0) ? e_acc[i-5] : 24'h0;
      v_m = (i - 5 >= 0) ? e_v[i-5] : 1'b0;
      if (s_show[i]) begin
        m_hi = a_m[23:8]; m_lo = a_m[15:0]; m_out = a_m[23:8];
        m_v = v_m; m_next_lo = 1;
      end else begin
        m_out = m_next_lo ? m_lo : m_hi;
        m_next_lo = !m_next_lo;
      end
      check(tag, out_word, m_out, out_valid, m_v & s_en[i]);
    end
    idle();
  endtask

  task automatic t_reset();
    clear_stim(); fill_random(6);
    run_seq("R11 warmup", 6);
    do_reset();
    check("R11 after reset", out_word, 16'h0, out_valid, 1'b0);
    @(negedge clk);
    check("R11 idle after reset", out_word, 16'h0, out_valid, 1'b0);
  endtask

  task automatic t_products();
    clear_stim(); fill_random(12);
    for (int i = 0; i < 12; i++) begin
      s_n1[i] = i[0]; s_n2[i] = i[1];
    end
    run_seq("R1 R2 products and latency", 12);
  endtask

  task automatic t_accum_round();
    clear_stim(); fill_random(16);
    for (int i = 0; i < 16; i++) begin
      s_acc[i] = (i % 4 != 0); s_rnd[i] = (i < 10);
      s_n1[i] = (i % 3 == 0);
    end
    run_seq("R3 R4 accumulate and first-cycle rounding", 16);
  endtask

  task automatic t_cascade();
    clear_stim(); fill_random(14);
    for (int i = 0; i < 14; i++) begin
      s_cas[i] = rnd16(); s_ign[i] = (i % 3 == 2); s_acc[i] = (i % 5 == 3);
    end
    run_seq("R5 cascade weight and ignore", 14);
  endtask

  task automatic t_fast();
    clear_stim(); fill_random(14);
    for (int i = 0; i < 20; i++) begin
      s_cas[i] = rnd16(); s_ign[i] = (i % 4 == 1);
      if (i < 14) s_fast[i] = (i % 2 == 0);
    end
    run_seq("R6 short cascade path", 14);
  endtask

  task automatic t_bubbles();
    clear_stim(); fill_random(15);
    for (int i = 0; i < 15; i++) begin
      s_vld[i] = (i % 3 != 1); s_acc[i] = (i != 0);
    end
    run_seq("R7 bubbles hold the sum", 15);
  endtask

  task automatic t_swap();
    clear_stim(); fill_random(16);
    for (int i = 0; i < 16; i++) begin
      s_acc[i] = (i % 2 == 1); s_rnd[i] = 1;
      s_show[i] = !(i >= 6 && i < 11);
    end
    for (int i = 19; i < 24; i++) s_show[i] = 0;
    run_seq("R8 word toggle", 16);
  endtask

  task automatic t_enable();
    clear_stim(); fill_random(12);
    for (int i = 0; i < 20; i++) s_en[i] = i[0];
    run_seq("R9 output enable", 12);
  endtask

  task automatic t_wrap();
    clear_stim();
    for (int i = 0; i < 10; i++) begin
      s_a[i] = 12'h800; s_b[i] = 12'h800; s_c[i] = 12'h800; s_d[i] = 12'h800;
      s_vld[i] = 1; s_acc[i] = (i != 0); s_show[i] = 1;
      s_n2[i] = (i >= 6);
    end
    run_seq("R10 modulo wrap", 10);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_stim();
    @(negedge clk);
    t_reset();
    t_products();
    t_accum_round();
    t_cascade();
    t_fast();
    t_bubbles();
    t_swap();
    t_enable();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule